// File: doc/BRIEF.md
# Phase-Accumulator PWM Generator

This block produces one pulse-width-modulated output from a single 32-bit control word. Instead of a period counter it keeps a 16-bit phase accumulator. On every clock the accumulator gains a programmable increment, so one output period lasts 65536 / increment clocks. The output frequency is therefore the clock rate times the increment divided by 65536.

Duty is set by an 8-bit threshold that works inverted. The output is high while the accumulator's upper byte is at or above the threshold, so a threshold of 255 gives the shortest high time and a threshold of 0 keeps the output high for the whole period.

Software writes the new increment and threshold into shadow fields and sets an update request. The block copies the shadow values into the active pair only at a period boundary, and it refuses an increment beyond the allowed maximum. A clear enable stops the accumulator and holds the output low.

Top module: `pwm_phase_gen`

## Requirements
- R1: After reset `rd_data` reads 0 and `pwm_out` is 0. The accumulator, the active increment and the active threshold are all 0.
- R2: The control word has this layout: bit 31 is enable, bit 30 is the update request, bits 23:8 are the increment and bits 7:0 are the threshold. A read returns the enable bit, the pending request and the two shadow fields in these same positions. Bits 29:24 read as 0.
- R3: While enabled, the accumulator adds the active increment each clock and wraps modulo 65536. An increment of N gives one output period, and one rising edge, per 65536/N clocks.
- R4: While enabled, `pwm_out` is 1 exactly when accumulator bits 15:8 are greater than or equal to the active threshold. A threshold of 0xFF gives no high time when the increment is 0x1000, and a threshold of 0x00 gives a constant high.
- R5: A write with bit 30 set leaves the active settings unchanged until the accumulator next wraps. Bit 30 reads 1 from the write until that transfer and reads 0 afterwards.
- R6: When the accumulator is not advancing (enable is 0 or the active increment is 0), a pending transfer happens on the next clock.
- R7: At transfer, a shadow increment above 0x8002 is rejected and both active fields keep their previous values. The request still clears. An increment of exactly 0x8002 is accepted.
- R8: With enable at 0, `pwm_out` is 0 and the accumulator is held at 0.
- R9: A write with bit 30 clear changes the enable bit and the shadow fields only. The active increment and threshold are left as they were.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock; the accumulator steps on each rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe for the control word |
| wr_data | input | 32 | Control word to be written |
| rd_data | output | 32 | Readback of enable, pending request and shadow fields |
| pwm_out | output | 1 | Modulated output |

## Verification
The hardest case to reach from the ports is a write that arrives in the middle of a period. At that moment the old settings must still drive the output while the request is visibly pending. The bench finds the moment by watching for a rising edge of the output, because with a known increment that edge marks a known accumulator phase. It writes a threshold that would force the output low, confirms the output stays high for the rest of that period, and then confirms the new threshold takes over after the wrap. The rejected-increment case is driven the same way: an out-of-range value is written over a known active pair, and the duty measured afterwards shows the old pair is still in force.

// File: rtl/pwm_phase_pkg.sv
package pwm_phase_pkg;
  localparam int REG_W      = 32;
  localparam int ACC_W_DEF  = 16;
  localparam int THR_W_DEF  = 8;
  localparam int EN_POS     = 31;
  localparam int REQ_POS    = 30;
  localparam logic [31:0] INC_MAX_DEF = 32'h0000_8002;

  // Increment acceptance test, done on zero-extended values.
  function automatic logic inc_acceptable(input logic [31:0] inc, input logic [31:0] max_inc);
    return inc <= max_inc;
  endfunction

  // Output level for one accumulator phase against the inverted threshold.
  function automatic logic level_for(input logic [31:0] phase_top, input logic [31:0] thr);
    return phase_top >= thr;
  endfunction
endpackage

// File: rtl/pwm_ctrl_reg.sv
module pwm_ctrl_reg
  import pwm_phase_pkg::*;
#(
  parameter int ACC_W = ACC_W_DEF,
  parameter int THR_W = THR_W_DEF
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [REG_W-1:0]  wr_data,
  input  logic              xfer,
  output logic              run_en,
  output logic              req_pend,
  output logic [ACC_W-1:0]  sh_inc,
  output logic [THR_W-1:0]  sh_thr,
  output logic [REG_W-1:0]  rd_data
);
  localparam int INC_LSB = THR_W;
  localparam int PAD_W   = REG_W - 2 - ACC_W - THR_W;

  logic unused_pad_bits;
  assign unused_pad_bits = ^wr_data[INC_LSB+ACC_W +: PAD_W];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_en   <= 1'b0;
      req_pend <= 1'b0;
      sh_inc   <= '0;
      sh_thr   <= '0;
    end else begin
      if (wr_en) begin
        run_en <= wr_data[EN_POS];
        sh_inc <= wr_data[INC_LSB +: ACC_W];
        sh_thr <= wr_data[0 +: THR_W];
      end
      // A new request wins over a transfer in the same cycle.
      if (wr_en && wr_data[REQ_POS])
        req_pend <= 1'b1;
      else if (xfer)
        req_pend <= 1'b0;
    end
  end

  assign rd_data = {run_en, req_pend, {PAD_W{1'b0}}, sh_inc, sh_thr};
endmodule

// File: rtl/pwm_active_set.sv
module pwm_active_set
  import pwm_phase_pkg::*;
#(
  parameter int          ACC_W   = ACC_W_DEF,
  parameter int          THR_W   = THR_W_DEF,
  parameter logic [31:0] INC_MAX = INC_MAX_DEF
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             xfer,
  input  logic [ACC_W-1:0] sh_inc,
  input  logic [THR_W-1:0] sh_thr,
  output logic             accept,
  output logic [ACC_W-1:0] act_inc,
  output logic [THR_W-1:0] act_thr
);
  assign accept = xfer && inc_acceptable(32'(sh_inc), INC_MAX);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_inc <= '0;
      act_thr <= '0;
    end else if (accept) begin
      act_inc <= sh_inc;
      act_thr <= sh_thr;
    end
  end
endmodule

// File: rtl/pwm_phase_acc.sv
module pwm_phase_acc #(
  parameter int ACC_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run_en,
  input  logic [ACC_W-1:0] inc,
  output logic [ACC_W-1:0] phase,
  output logic             wrap
);
  logic [ACC_W:0] sum_ext;

  assign sum_ext = {1'b0, phase} + {1'b0, inc};
  assign wrap    = run_en && sum_ext[ACC_W];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      phase <= '0;
    else if (!run_en)
      phase <= '0;
    else
      phase <= sum_ext[ACC_W-1:0];
  end
endmodule

// File: rtl/pwm_phase_gen.sv
module pwm_phase_gen
  import pwm_phase_pkg::*;
#(
  parameter int          ACC_W   = ACC_W_DEF,
  parameter int          THR_W   = THR_W_DEF,
  parameter logic [31:0] INC_MAX = INC_MAX_DEF
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic [31:0] wr_data,
  output logic [31:0] rd_data,
  output logic        pwm_out
);
  logic             run_en, req_pend, accept, wrap;
  logic             advancing, boundary, xfer;
  logic [ACC_W-1:0] sh_inc, act_inc, phase;
  logic [THR_W-1:0] sh_thr, act_thr;

  pwm_ctrl_reg #(.ACC_W(ACC_W), .THR_W(THR_W)) u_reg (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data), .xfer(xfer),
    .run_en(run_en), .req_pend(req_pend), .sh_inc(sh_inc), .sh_thr(sh_thr),
    .rd_data(rd_data)
  );

  pwm_active_set #(.ACC_W(ACC_W), .THR_W(THR_W), .INC_MAX(INC_MAX)) u_act (
    .clk(clk), .rst_n(rst_n), .xfer(xfer), .sh_inc(sh_inc), .sh_thr(sh_thr),
    .accept(accept), .act_inc(act_inc), .act_thr(act_thr)
  );

  pwm_phase_acc #(.ACC_W(ACC_W)) u_acc (
    .clk(clk), .rst_n(rst_n), .run_en(run_en), .inc(act_inc),
    .phase(phase), .wrap(wrap)
  );

  // A period boundary is a wrap; a stalled accumulator is always at one.
  assign advancing = run_en && (act_inc != '0);
  assign boundary  = wrap || !advancing;
  assign xfer      = req_pend && boundary;

  assign pwm_out = run_en && level_for(32'(phase[ACC_W-1 -: THR_W]), 32'(act_thr));
endmodule

// File: rtl/pwm_phase_chk.sv
module pwm_phase_chk #(
  parameter int          ACC_W   = 16,
  parameter int          THR_W   = 8,
  parameter logic [31:0] INC_MAX = 32'h8002
) (
  input logic             clk,
  input logic             rst_n,
  input logic             run_en,
  input logic             req_pend,
  input logic             xfer,
  input logic             wrap,
  input logic [ACC_W-1:0] act_inc,
  input logic [THR_W-1:0] act_thr,
  input logic [ACC_W-1:0] phase,
  input logic             pwm_out
);
  // R8: a disabled block drives nothing
  a_r8_off_low: assert property (@(posedge clk) disable iff (!rst_n)
    !run_en |-> !pwm_out);

  // R8: accumulator returns to zero while disabled
  a_r8_phase_clear: assert property (@(posedge clk) disable iff (!rst_n)
    !run_en |=> (phase == '0));

  // R5: a request stays visible until it is serviced
  a_r5_pend_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (req_pend && !xfer) |=> req_pend);

  // R9: active pair moves only on a transfer
  a_r9_active_stable: assert property (@(posedge clk) disable iff (!rst_n)
    !xfer |=> ($stable(act_inc) && $stable(act_thr)));

  // R7: active increment never exceeds the limit
  a_r7_inc_limit: assert property (@(posedge clk) disable iff (!rst_n)
    32'(act_inc) <= INC_MAX);

  // R3: a wrap happens only while running
  a_r3_wrap_running: assert property (@(posedge clk) disable iff (!rst_n)
    wrap |-> run_en);
endmodule

bind pwm_phase_gen pwm_phase_chk #(.ACC_W(ACC_W), .THR_W(THR_W), .INC_MAX(INC_MAX)) u_chk (
  .clk(clk), .rst_n(rst_n), .run_en(run_en), .req_pend(req_pend), .xfer(xfer),
  .wrap(wrap), .act_inc(act_inc), .act_thr(act_thr), .phase(phase), .pwm_out(pwm_out)
);

// File: tb/tb_pwm_phase_gen.sv
module tb_pwm_phase_gen;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [31:0] wr_data = '0;
  logic [31:0] rd_data;
  logic        pwm_out;

  int n_chk = 0;
  int n_bad = 0;
  int cyc = 0;

  always #4 clk = ~clk;

  pwm_phase_gen dut (.clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
                     .rd_data(rd_data), .pwm_out(pwm_out));

  // Fields {inc[15:0], thr[7:0], high count per 256 clocks, rising edges per 256 clocks}
  localparam logic [55:0] VEC [5] = '{
    {16'h1000, 8'h80, 16'd128, 16'd16},
    {16'h0800, 8'h40, 16'd192, 16'd8},
    {16'h8000, 8'h80, 16'd128, 16'd128},
    {16'h1000, 8'hFF, 16'd0,   16'd0},
    {16'h1000, 8'h00, 16'd256, 16'd0}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] word(input logic en, input logic req,
                                       input logic [15:0] inc, input logic [7:0] thr);
    return {en, req, 6'b0, inc, thr};
  endfunction

  task automatic do_write(input logic [31:0] w);
    wr_data = w;
    wr_en   = 1'b1;
    @(negedge clk);
    wr_en   = 1'b0;
  endtask

  task automatic wait_clear();
    for (int i = 0; i < 200; i++) begin
      if (!rd_data[30]) break;
      @(negedge clk);
    end
  endtask

  task automatic measure(input int len, output int hi, output int rises);
    logic prev;
    prev  = pwm_out;
    hi    = 0;
    rises = 0;
    for (int i = 0; i < len; i++) begin
      @(negedge clk);
      if (pwm_out) hi++;
      if (pwm_out && !prev) rises++;
      prev = pwm_out;
    end
  endtask

  task automatic settle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog actual=%0d expected<150000", cyc);
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    int hi, ri;
    logic prev;
    @(negedge clk);
    @(negedge clk);
    // R1: reset state
    check("R1 rd_data", rd_data, 32'h0);
    check("R1 pwm_out", 32'(pwm_out), 32'h0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 pwm_out after release", 32'(pwm_out), 32'h0);

    // R6 and R2: stalled accumulator transfers on the next clock
    do_write(word(1'b1, 1'b1, 16'h1000, 8'h80));
    check("R2 readback pending", rd_data, 32'hC010_0080);
    @(negedge clk);
    check("R6 immediate transfer", 32'(rd_data[30]), 32'h0);

    // R3 R4: vector walk
    foreach (VEC[k]) begin
      do_write(word(1'b1, 1'b1, VEC[k][55:40], VEC[k][39:32]));
      wait_clear();
      settle(64);
      measure(256, hi, ri);
      check($sformatf("R4 high count vec%0d", k), 32'(hi), 32'(VEC[k][31:16]));
      check($sformatf("R3 rising edges vec%0d", k), 32'(ri), 32'(VEC[k][15:0]));
    end

    // R5: mid-period request is deferred to the wrap
    do_write(word(1'b1, 1'b1, 16'h1000, 8'h80));
    wait_clear();
    settle(20);
    prev = pwm_out;
    for (int i = 0; i < 64; i++) begin
      @(negedge clk);
      if (pwm_out && !prev) break;
      prev = pwm_out;
    end
    do_write(word(1'b1, 1'b1, 16'h1000, 8'hFF));
    check("R5 pending after write", 32'(rd_data[30]), 32'h1);
    hi = 0;
    for (int i = 0; i < 5; i++) begin
      if (pwm_out) hi++;
      @(negedge clk);
    end
    check("R5 old duty kept until wrap", 32'(hi), 32'd5);
    settle(16);
    check("R5 pending cleared after wrap", 32'(rd_data[30]), 32'h0);
    measure(32, hi, ri);
    check("R5 new threshold active", 32'(hi), 32'd0);

    // R7: out-of-range increment rejected
    do_write(word(1'b1, 1'b1, 16'h1000, 8'h80));
    wait_clear();
    do_write(word(1'b1, 1'b1, 16'h8003, 8'h00));
    wait_clear();
    check("R7 request cleared on reject", 32'(rd_data[30]), 32'h0);
    check("R2 shadow inc readback", 32'(rd_data[23:8]), 32'h8003);
    settle(16);
    measure(256, hi, ri);
    check("R7 rejected keeps duty", 32'(hi), 32'd128);
    check("R7 rejected keeps freq", 32'(ri), 32'd16);
    do_write(word(1'b1, 1'b1, 16'h8002, 8'h00));
    wait_clear();
    settle(4);
    measure(64, hi, ri);
    check("R7 limit value accepted", 32'(hi), 32'd64);

    // R8 R9: disable, then enable-only write
    do_write(word(1'b1, 1'b1, 16'h1000, 8'h80));
    wait_clear();
    do_write(word(1'b0, 1'b0, 16'h2000, 8'h00));
    measure(32, hi, ri);
    check("R8 disabled output low", 32'(hi), 32'd0);
    check("R8 enable bit reads 0", 32'(rd_data[31]), 32'h0);
    do_write(word(1'b1, 1'b0, 16'h2000, 8'h00));
    check("R9 no request raised", 32'(rd_data[30]), 32'h0);
    measure(256, hi, ri);
    check("R9 active duty unchanged", 32'(hi), 32'd128);
    check("R9 active freq unchanged", 32'(ri), 32'd16);
    check("R9 shadow updated", rd_data, 32'h8020_0000);

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule